// File: doc/BRIEF.md
# Li-Ion Charge Control Sequencer

This block is the digital sequencer of a linear single-cell lithium-ion charger. It reads the flags of the analog comparators that sit around the power stage. These flags report a shorted battery, the low-voltage threshold, the regulation voltage, the recharge margin, the termination current, thermistor presence and hot or cold, input power, over-voltage, and the regulation loops that cut the current. From these flags it picks the charge mode for the power stage and the current scale (full or one tenth). It also enables thermistor sensing, drives an open-drain status sink for an LED and raises a latched fault.

A charge cycle starts with a one-cycle battery check. It then runs pre-charge, fast current and constant voltage, ends at termination, and re-arms for a recharge when the battery sags. One safety counter, stepped by a one-second tick, limits pre-charge and limits the combined fast-current and constant-voltage time. While a current-reducing loop is active the counter steps at a reduced rate. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `chg_seq_top`

## Requirements
- R1: After reset the block is idle. `mode_o` is 2'b00 (off), and `stat_sink_o`, `fault_o`, `cur_tenth_o` and `ts_sense_en_o` are all 0.
- R2: A charge start needs `chg_en` high, `pwr_good` high and `ovp` low. It first spends one cycle checking the battery with the mode off. If `bat_short` is high at that check, the block enters the fault state.
- R3: Pre-charge drives `mode_o`=2'b01 with `cur_tenth_o`=1. Once `bat_lowv_ok` is high it moves to fast current, `mode_o`=2'b10 with `cur_tenth_o`=0. A start with `bat_lowv_ok` already high skips pre-charge.
- R4: Fast current moves to constant voltage, `mode_o`=2'b11, when `at_vreg` is high. `stat_sink_o` is 1 in pre-charge, fast current and constant voltage.
- R5: Constant voltage terminates when `i_term` is high and `loop_reduce` is low. Termination gives `mode_o`=2'b00 with `stat_sink_o`=0. While `loop_reduce` is high, `i_term` is ignored.
- R6: If the safety counter reaches PRE_LIMIT steps in pre-charge, the block enters the fault state one cycle later.
- R7: The fast-current limit FAST_LIMIT counts from entry into fast current, or from a direct entry into constant voltage. The count carries across the move into constant voltage, and reaching the limit gives a fault.
- R8: While `loop_reduce` is high, the safety counter steps once per SLOW_DIV ticks instead of on every tick.
- R9: After termination, `below_rch` starts a recharge if `bat_short` is low: `mode_o`=2'b10, `stat_sink_o`=0. The recharge returns to the terminated state when `at_vreg` is high. If `bat_short` is high the block faults instead.
- R10: `ts_sense_en_o` is 1 only while charging (pre-charge, fast, constant voltage, recharge) with `ts_present` high. While sensing, `ts_hotcold` forces `mode_o` to 2'b00 and freezes the safety counter. `ts_hotcold` has no effect when `ts_present` is low.
- R11: `fault_o` stays 1, over `ovp` and any comparator change, until `chg_en` or `pwr_good` goes low. The block is then idle one cycle later.
- R12: Dropping `chg_en` or raising `ovp` outside the fault state returns the block to idle one cycle later, with mode off and the status sink released. No new charge starts while `ovp` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_en | input | 1 | Charger enable |
| pwr_good | input | 1 | Input supply present and above lockout |
| ovp | input | 1 | Input over-voltage |
| tick_1s | input | 1 | One-cycle pulse per second |
| bat_short | input | 1 | Battery below short threshold (damaged or absent) |
| bat_lowv_ok | input | 1 | Battery above the pre-charge threshold |
| at_vreg | input | 1 | Battery at regulation voltage |
| below_rch | input | 1 | Battery a recharge margin below regulation |
| i_term | input | 1 | Charge current below termination level |
| ts_present | input | 1 | Thermistor detected |
| ts_hotcold | input | 1 | Thermistor outside the charge window |
| loop_reduce | input | 1 | Thermal, DPM or input-limit loop reducing current |
| mode_o | output | 2 | 00 off, 01 pre-charge, 10 fast current, 11 constant voltage |
| cur_tenth_o | output | 1 | Current DAC at one tenth scale |
| ts_sense_en_o | output | 1 | Thermistor sense enable |
| stat_sink_o | output | 1 | Status open-drain sink on (LED lit) |
| fault_o | output | 1 | Latched charge fault |

## Verification
Every output decodes the registered state directly, so a comparator change driven between edges shows at the outputs after the next rising edge. The one exception is the thermistor suspend, which gates the mode at once. Safety-counter expiry costs one edge more than the step that reaches the limit. A timed-out pre-charge therefore faults at the 23rd edge after enable with the test limit of 20, and at the 43rd when stepping at half rate. The scoreboard gives each expected value an absolute due cycle when the stimulus is driven. The monitor compares it on the falling edge of exactly that cycle, and flags any entry whose cycle has passed.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [1:0] {
    CM_OFF  = 2'b00,
    CM_PRE  = 2'b01,
    CM_FAST = 2'b10,
    CM_CV   = 2'b11
  } chg_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DETECT,
    ST_PRE,
    ST_FAST,
    ST_CV,
    ST_DONE,
    ST_RECHG,
    ST_FAULT
  } chg_state_e;

endpackage

// File: rtl/chg_tick_scaler.sv
module chg_tick_scaler #(
  parameter int SLOW_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic slow_i,
  output logic step_o
);

  generate
    if (SLOW_DIV <= 1) begin : g_direct
      assign step_o = tick_i;
    end else begin : g_div
      localparam int DW = $clog2(SLOW_DIV);
      localparam logic [DW-1:0] LAST = DW'(SLOW_DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (!slow_i)          div_q <= '0;
        else if (tick_i) begin
          if (div_q == LAST)       div_q <= '0;
          else                     div_q <= div_q + 1'b1;
        end
      end

      assign step_o = tick_i && (!slow_i || div_q == LAST);

      // R8
      slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_i && step_o) |=> (!slow_i || !step_o));
    end
  endgenerate

endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
  parameter int PRE_LIMIT  = 1800,
  parameter int FAST_LIMIT = 18000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic step_i,
  input  logic sel_pre_i,
  output logic expired_o
);

  localparam int MAXL = (PRE_LIMIT > FAST_LIMIT) ? PRE_LIMIT : FAST_LIMIT;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] PRE_L  = CW'(PRE_LIMIT);
  localparam logic [CW-1:0] FAST_L = CW'(FAST_LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit     = sel_pre_i ? PRE_L : FAST_L;
  assign expired_o = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (clr_i)                          cnt_q <= '0;
    else if (run_i && step_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));

  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chg_en_i,
  input  logic       pwr_good_i,
  input  logic       ovp_i,
  input  logic       bat_short_i,
  input  logic       bat_lowv_ok_i,
  input  logic       at_vreg_i,
  input  logic       below_rch_i,
  input  logic       i_term_i,
  input  logic       ts_present_i,
  input  logic       ts_hotcold_i,
  input  logic       loop_reduce_i,
  input  logic       expired_i,
  output logic       tmr_clr_o,
  output logic       tmr_run_o,
  output logic       tmr_sel_pre_o,
  output chg_mode_e  mode_o,
  output logic       cur_tenth_o,
  output logic       ts_sense_en_o,
  output logic       stat_sink_o,
  output logic       fault_o
);

  chg_state_e st_q, st_d;
  logic charging, suspend;

  always_comb begin
    st_d = st_q;
    if (!chg_en_i || !pwr_good_i) begin
      st_d = ST_IDLE;
    end else if (ovp_i && st_q != ST_FAULT) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   st_d = ST_DETECT;
        ST_DETECT: begin
          if (bat_short_i)         st_d = ST_FAULT;
          else if (!bat_lowv_ok_i) st_d = ST_PRE;
          else if (at_vreg_i)      st_d = ST_CV;
          else                     st_d = ST_FAST;
        end
        ST_PRE: begin
          if (expired_i)           st_d = ST_FAULT;
          else if (bat_lowv_ok_i)  st_d = ST_FAST;
        end
        ST_FAST: begin
          if (expired_i)           st_d = ST_FAULT;
          else if (at_vreg_i)      st_d = ST_CV;
        end
        ST_CV: begin
          if (expired_i)                       st_d = ST_FAULT;
          else if (i_term_i && !loop_reduce_i) st_d = ST_DONE;
        end
        ST_DONE: begin
          if (below_rch_i)         st_d = bat_short_i ? ST_FAULT : ST_RECHG;
        end
        ST_RECHG: begin
          if (expired_i)           st_d = ST_FAULT;
          else if (at_vreg_i)      st_d = ST_DONE;
        end
        ST_FAULT:                  st_d = ST_FAULT;
        default:                   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign charging = (st_q == ST_PRE) || (st_q == ST_FAST) ||
                    (st_q == ST_CV)  || (st_q == ST_RECHG);
  assign ts_sense_en_o = charging && ts_present_i;
  assign suspend       = ts_sense_en_o && ts_hotcold_i;

  assign tmr_run_o     = charging && !suspend;
  assign tmr_clr_o     = !charging || (st_q == ST_PRE && st_d != ST_PRE);
  assign tmr_sel_pre_o = (st_q == ST_PRE);

  always_comb begin
    unique case (st_q)
      ST_PRE:           mode_o = CM_PRE;
      ST_FAST, ST_RECHG: mode_o = CM_FAST;
      ST_CV:            mode_o = CM_CV;
      default:          mode_o = CM_OFF;
    endcase
    if (suspend) mode_o = CM_OFF;
  end

  assign cur_tenth_o = (st_q == ST_PRE);
  assign stat_sink_o = (st_q == ST_PRE) || (st_q == ST_FAST) || (st_q == ST_CV);
  assign fault_o     = (st_q == ST_FAULT);

  // R5
  no_term_reduce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CV && loop_reduce_i) |=> (st_q != ST_DONE));

  // R11
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAULT && chg_en_i && pwr_good_i) |=> (st_q == ST_FAULT));

  // R12
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_en_i) |=> (st_q == ST_IDLE));

  // R2
  detect_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DETECT && bat_short_i && chg_en_i && pwr_good_i) |=> (st_q == ST_FAULT));

endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_seq_pkg::*;
#(
  parameter int PRE_LIMIT  = 1800,
  parameter int FAST_LIMIT = 18000,
  parameter int SLOW_DIV   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chg_en,
  input  logic       pwr_good,
  input  logic       ovp,
  input  logic       tick_1s,
  input  logic       bat_short,
  input  logic       bat_lowv_ok,
  input  logic       at_vreg,
  input  logic       below_rch,
  input  logic       i_term,
  input  logic       ts_present,
  input  logic       ts_hotcold,
  input  logic       loop_reduce,
  output logic [1:0] mode_o,
  output logic       cur_tenth_o,
  output logic       ts_sense_en_o,
  output logic       stat_sink_o,
  output logic       fault_o
);

  logic step, expired, tmr_clr, tmr_run, tmr_sel_pre;
  chg_mode_e mode;

  chg_tick_scaler #(.SLOW_DIV(SLOW_DIV)) u_scaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_1s),
    .slow_i (loop_reduce),
    .step_o (step)
  );

  chg_safety_timer #(.PRE_LIMIT(PRE_LIMIT), .FAST_LIMIT(FAST_LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .run_i     (tmr_run),
    .step_i    (step),
    .sel_pre_i (tmr_sel_pre),
    .expired_o (expired)
  );

  chg_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .chg_en_i      (chg_en),
    .pwr_good_i    (pwr_good),
    .ovp_i         (ovp),
    .bat_short_i   (bat_short),
    .bat_lowv_ok_i (bat_lowv_ok),
    .at_vreg_i     (at_vreg),
    .below_rch_i   (below_rch),
    .i_term_i      (i_term),
    .ts_present_i  (ts_present),
    .ts_hotcold_i  (ts_hotcold),
    .loop_reduce_i (loop_reduce),
    .expired_i     (expired),
    .tmr_clr_o     (tmr_clr),
    .tmr_run_o     (tmr_run),
    .tmr_sel_pre_o (tmr_sel_pre),
    .mode_o        (mode),
    .cur_tenth_o   (cur_tenth_o),
    .ts_sense_en_o (ts_sense_en_o),
    .stat_sink_o   (stat_sink_o),
    .fault_o       (fault_o)
  );

  assign mode_o = mode;

  // R3
  pre_tenth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == CM_PRE) |-> cur_tenth_o);

  // R1
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (mode_o == CM_OFF && !stat_sink_o));

endmodule

// File: tb/chg_seq_top_test.sv
module chg_seq_top_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chg_en, pwr_good, ovp, tick_1s, bat_short, bat_lowv_ok, at_vreg;
  logic below_rch, i_term, ts_present, ts_hotcold, loop_reduce;
  logic [1:0] mode_o;
  logic cur_tenth_o, ts_sense_en_o, stat_sink_o, fault_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done_flag = 0;

  typedef struct {
    int         due;
    logic [5:0] val;  // {mode, stat, fault, tenth, ts_en}
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chg_seq_top #(.PRE_LIMIT(20), .FAST_LIMIT(60), .SLOW_DIV(2)) uut (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .pwr_good(pwr_good), .ovp(ovp),
    .tick_1s(tick_1s), .bat_short(bat_short), .bat_lowv_ok(bat_lowv_ok),
    .at_vreg(at_vreg), .below_rch(below_rch), .i_term(i_term),
    .ts_present(ts_present), .ts_hotcold(ts_hotcold), .loop_reduce(loop_reduce),
    .mode_o(mode_o), .cur_tenth_o(cur_tenth_o), .ts_sense_en_o(ts_sense_en_o),
    .stat_sink_o(stat_sink_o), .fault_o(fault_o)
  );

  // monitor: compare scoreboard entries in their due cycle
  always @(negedge clk) begin
    logic [5:0] act;
    act = {mode_o, stat_sink_o, fault_o, cur_tenth_o, ts_sense_en_o};
    while (q.size() > 0 && q[0].due <= cyc) begin
      checks++;
      if (q[0].due < cyc) begin
        fails++;
        $display("FAIL %s: entry for cycle %0d missed (now %0d)", q[0].tag, q[0].due, cyc);
      end else if (act !== q[0].val) begin
        fails++;
        $display("FAIL %s: cycle %0d actual %b expected %b", q[0].tag, cyc, act, q[0].val);
      end
      void'(q.pop_front());
    end
  end

  task automatic expect_at(int due, logic [1:0] m, logic st, logic f,
                           logic sc, logic ts, string tag);
    exp_t e;
    e.due = due;
    e.val = {m, st, f, sc, ts};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic at(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic defaults();
    chg_en = 0; pwr_good = 1; ovp = 0; tick_1s = 0; bat_short = 0;
    bat_lowv_ok = 0; at_vreg = 0; below_rch = 0; i_term = 0;
    ts_present = 0; ts_hotcold = 0; loop_reduce = 0;
  endtask

  task automatic go_idle(string tag);
    @(negedge clk);
    defaults();
    expect_at(cyc + 1, 2'b00, 0, 0, 0, 0, tag);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int t0;
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_at(cyc + 1, 2'b00, 0, 0, 0, 0, "R1");
    repeat (2) @(negedge clk);

    // R2 shorted battery, R11 latch over input changes
    @(negedge clk); t0 = cyc;
    chg_en = 1; bat_short = 1;
    expect_at(t0 + 1, 2'b00, 0, 0, 0, 0, "R2");
    expect_at(t0 + 2, 2'b00, 0, 1, 0, 0, "R2");
    at(t0 + 3); bat_short = 0; bat_lowv_ok = 1;
    expect_at(t0 + 5, 2'b00, 0, 1, 0, 0, "R11");
    at(t0 + 5);
    go_idle("R11");

    // R3 R4 R5 R9 full cycle with thermistor present
    @(negedge clk); t0 = cyc;
    chg_en = 1; ts_present = 1;
    expect_at(t0 + 2, 2'b01, 1, 0, 1, 1, "R3");
    at(t0 + 4); bat_lowv_ok = 1;
    expect_at(t0 + 5, 2'b10, 1, 0, 0, 1, "R3");
    at(t0 + 6); at_vreg = 1;
    expect_at(t0 + 7, 2'b11, 1, 0, 0, 1, "R4");
    at(t0 + 8); i_term = 1; loop_reduce = 1;
    expect_at(t0 + 10, 2'b11, 1, 0, 0, 1, "R5");
    at(t0 + 10); loop_reduce = 0;
    expect_at(t0 + 11, 2'b00, 0, 0, 0, 0, "R5");
    at(t0 + 12); at_vreg = 0; below_rch = 1;
    expect_at(t0 + 13, 2'b10, 0, 0, 0, 1, "R9");
    at(t0 + 14); below_rch = 0; at_vreg = 1;
    expect_at(t0 + 15, 2'b00, 0, 0, 0, 0, "R9");
    at(t0 + 16); at_vreg = 0; below_rch = 1; bat_short = 1;
    expect_at(t0 + 17, 2'b00, 0, 1, 0, 0, "R9");
    at(t0 + 17);
    go_idle("R12");

    // R6 pre-charge timeout
    @(negedge clk); t0 = cyc;
    chg_en = 1; tick_1s = 1;
    expect_at(t0 + 22, 2'b01, 1, 0, 1, 0, "R6");
    expect_at(t0 + 23, 2'b00, 0, 1, 0, 0, "R6");
    at(t0 + 23);
    go_idle("R12");

    // R8 half-rate stepping while a loop reduces current
    @(negedge clk); t0 = cyc;
    chg_en = 1; tick_1s = 1; loop_reduce = 1;
    expect_at(t0 + 42, 2'b01, 1, 0, 1, 0, "R8");
    expect_at(t0 + 43, 2'b00, 0, 1, 0, 0, "R8");
    at(t0 + 43);
    go_idle("R12");

    // R7 fast limit spans constant voltage; R10 hot/cold ignored without thermistor
    @(negedge clk); t0 = cyc;
    chg_en = 1; tick_1s = 1; bat_lowv_ok = 1;
    expect_at(t0 + 5, 2'b10, 1, 0, 0, 0, "R7");
    at(t0 + 10); at_vreg = 1;
    expect_at(t0 + 12, 2'b11, 1, 0, 0, 0, "R4");
    at(t0 + 20); ts_hotcold = 1;
    expect_at(t0 + 21, 2'b11, 1, 0, 0, 0, "R10");
    expect_at(t0 + 62, 2'b11, 1, 0, 0, 0, "R7");
    expect_at(t0 + 63, 2'b00, 0, 1, 0, 0, "R7");
    at(t0 + 63);
    go_idle("R12");

    // R10 thermistor suspend freezes the timer
    @(negedge clk); t0 = cyc;
    chg_en = 1; tick_1s = 1; bat_lowv_ok = 1; ts_present = 1;
    at(t0 + 2); ts_hotcold = 1;
    expect_at(t0 + 3, 2'b00, 1, 0, 0, 1, "R10");
    at(t0 + 22); ts_hotcold = 0;
    expect_at(t0 + 23, 2'b10, 1, 0, 0, 1, "R10");
    expect_at(t0 + 82, 2'b10, 1, 0, 0, 1, "R10");
    expect_at(t0 + 83, 2'b00, 0, 1, 0, 0, "R10");
    at(t0 + 83);
    go_idle("R12");

    // R12 over-voltage aborts and blocks restart
    @(negedge clk); t0 = cyc;
    chg_en = 1;
    expect_at(t0 + 2, 2'b01, 1, 0, 1, 0, "R12");
    at(t0 + 4); ovp = 1;
    expect_at(t0 + 5, 2'b00, 0, 0, 0, 0, "R12");
    expect_at(t0 + 7, 2'b00, 0, 0, 0, 0, "R12");
    at(t0 + 7); ovp = 0;
    expect_at(t0 + 9, 2'b01, 1, 0, 1, 0, "R12");
    at(t0 + 9);
    go_idle("R12");

    // R11 fault holds over ovp, clears on power loss
    @(negedge clk); t0 = cyc;
    chg_en = 1; bat_short = 1;
    expect_at(t0 + 2, 2'b00, 0, 1, 0, 0, "R2");
    at(t0 + 3); ovp = 1;
    expect_at(t0 + 4, 2'b00, 0, 1, 0, 0, "R11");
    at(t0 + 4); pwr_good = 0;
    expect_at(t0 + 5, 2'b00, 0, 0, 0, 0, "R11");
    at(t0 + 5);
    go_idle("R11");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule